// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM command bus. It runs the required start-up command sequence once after reset and then hands the bus over. The sequence waits until the supplies and the clock have been flagged stable. It holds the bus in Deselect with the clock enable low for a wall-clock delay, and the length of that delay is derived from a clock-period parameter. It then raises the clock enable with a NOP and steps through seven commands in a fixed order:

1. precharge all banks;
2. extended mode register write that enables the DLL;
3. base mode register write with the DLL-reset bit set;
4. a second precharge all, after a counted DLL-lock window;
5. first auto refresh;
6. second auto refresh;
7. base mode register write with the DLL-reset bit cleared.

Every command is followed by NOP cycles that respect a parameterized minimum spacing. The DLL-lock window is counted from the DLL-reset write and overlaps the mode-register spacing that follows it. When the last spacing has elapsed, a done flag rises and stays high. The bus then idles on NOP with the clock enable high until the normal scheduler takes over.

The mode register contents, the DLL-reset bit position, the spacings and the wait time are all parameters. All pin outputs come from flops.

Top module: `ddr_init_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the outputs after that edge are cke_o low, cs_n_o high, and init_done_o low.
- R2: The sequencer holds cke_o low and cs_n_o high (Deselect) until pwr_stable_i has been high for at least WAIT_CYC consecutive cycles. WAIT_CYC is ceil(WAIT_US·10^6 / CLK_PERIOD_PS). A low cycle on pwr_stable_i restarts the count.
- R3: The first cycle with cke_o high carries a NOP. cke_o then stays high until the next reset.
- R4: After cke_o rises, exactly seven executable commands are issued, in this order:
  1. precharge all;
  2. extended mode register write;
  3. base mode register write with DLL reset;
  4. precharge all;
  5. auto refresh;
  6. auto refresh;
  7. base mode register write without DLL reset.
- R5: Commands are encoded on {cs_n_o, ras_n_o, cas_n_o, we_n_o} as follows:
  - NOP is 0111;
  - precharge is 0010, with addr_o bit 10 set for all banks;
  - auto refresh is 0001;
  - mode register write is 0000;
  - after cke_o rises, every non-command cycle is a NOP.
- R6: Mode register writes select their target through ba_o:
  - the extended write uses ba_o = 01 and addr_o = EMR_VALUE;
  - the first base write uses ba_o = 00 and MR_VALUE with bit DLL_RST_BIT set;
  - the final base write uses ba_o = 00 and MR_VALUE with bit DLL_RST_BIT cleared.
- R7: The gap from a command to the next one is at least T_RP cycles after a precharge, T_MRD cycles after a mode register write, and T_RFC cycles after an auto refresh.
- R8: The second precharge comes at least DLL_LOCK_CYC cycles after the DLL-reset write, with only NOPs in between.
- R9: init_done_o rises at least T_MRD cycles after the final mode register write. From then on it stays high, and the bus carries only NOP with cke_o high.
- R10: A reset in the middle of the sequence returns the block to the power-up wait. A later full run then repeats the complete sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_stable_i | input | 1 | Supplies, reference and clock are stable |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address (mode register select during writes) |
| addr_o | output | ADDR_W | Address bus (mode value or all-bank flag) |
| init_done_o | output | 1 | Sequence complete, sticky until reset |

## Verification
The bench builds the block with an 8000 ps clock period and a 2 µs wait, which gives a power-up wait of 250 cycles. With that setting a reset in the middle of the sequence, followed by a second complete run, fits in a short simulation. DLL_LOCK_CYC stays at 200, so the DLL-lock window is far longer than T_MRD = 2. This shows that the second precharge is held back by the lock window rather than by the mode-register spacing. T_RP = 3 and T_RFC = 9 are distinct, so a spacing taken from the wrong parameter shows up. MR_VALUE has the DLL-reset bit already set, so the final write must actively clear it.

// File: rtl/ddr_init_pkg.sv
// Package: ddr_init_pkg
// Shared types for the power-up sequencer: the sequence steps and the
// abstract commands the step machine hands to the pin driver.
// Assumes: nothing beyond SystemVerilog-2017 enums.
package ddr_init_pkg;

    typedef enum logic [3:0] {
        ST_PWAIT,
        ST_CKE,
        ST_PRE1,
        ST_EMR,
        ST_MR_DLLRST,
        ST_PRE2,
        ST_REF1,
        ST_REF2,
        ST_MR_RUN,
        ST_TAIL,
        ST_DONE
    } init_step_e;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_PRE_ALL,
        CMD_REFRESH,
        CMD_MRS_EXT,
        CMD_MRS_DLLRST,
        CMD_MRS_RUN
    } init_cmd_e;

endpackage

// File: rtl/ddr_init_timer.sv
// Module: ddr_init_timer
// Loadable down counter shared by every wait of the sequence. A load
// takes priority; otherwise the counter moves toward zero and holds there.
// Assumes: load values fit in CW bits; reset value given by RST_VAL.
module ddr_init_timer #(
    parameter int          CW      = 8,
    parameter logic [CW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);

    logic [CW-1:0] cnt_q;

    // Count down, reload on request, restart from RST_VAL on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    AST_HOLDS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o); // R7

endmodule

// File: rtl/ddr_init_fsm.sv
// Module: ddr_init_fsm
// Step machine of the power-up sequence. Each command step waits for the
// shared timer to expire, issues its command for one cycle, loads the
// spacing that must follow it and moves on.
// Assumes: all spacings are at least 1 cycle; timer value 0 means expired.
module ddr_init_fsm
    import ddr_init_pkg::*;
#(
    parameter int CW        = 8,
    parameter int WAIT_CYC  = 250,
    parameter int T_RP      = 3,
    parameter int T_MRD     = 2,
    parameter int T_RFC     = 9,
    parameter int LOCK_GAP  = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_stable_i,
    input  logic          tmr_zero_i,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_val_o,
    output logic          issue_o,
    output init_cmd_e     cmd_o,
    output logic          cke_en_o,
    output logic          done_o
);

    init_step_e step_q, step_d;

    // Hold the current step; reset restarts at the power-up wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_PWAIT;
        end else begin
            step_q <= step_d;
        end
    end

    // Pick the command of the current step and the spacing that follows it.
    always_comb begin
        step_d     = step_q;
        issue_o    = 1'b0;
        cmd_o      = CMD_NOP;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        case (step_q)
            ST_PWAIT: begin
                if (!pwr_stable_i) begin
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CW'(WAIT_CYC - 1);
                end else if (tmr_zero_i) begin
                    step_d = ST_CKE;
                end
            end
            ST_CKE: begin
                tmr_load_o = 1'b1;
                tmr_val_o  = '0;
                step_d     = ST_PRE1;
            end
            ST_PRE1, ST_PRE2: begin
                if (tmr_zero_i) begin
                    issue_o    = 1'b1;
                    cmd_o      = CMD_PRE_ALL;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CW'(T_RP - 1);
                    step_d     = (step_q == ST_PRE1) ? ST_EMR : ST_REF1;
                end
            end
            ST_EMR: begin
                if (tmr_zero_i) begin
                    issue_o    = 1'b1;
                    cmd_o      = CMD_MRS_EXT;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CW'(T_MRD - 1);
                    step_d     = ST_MR_DLLRST;
                end
            end
            ST_MR_DLLRST: begin
                if (tmr_zero_i) begin
                    issue_o    = 1'b1;
                    cmd_o      = CMD_MRS_DLLRST;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CW'(LOCK_GAP - 1);
                    step_d     = ST_PRE2;
                end
            end
            ST_REF1, ST_REF2: begin
                if (tmr_zero_i) begin
                    issue_o    = 1'b1;
                    cmd_o      = CMD_REFRESH;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CW'(T_RFC - 1);
                    step_d     = (step_q == ST_REF1) ? ST_REF2 : ST_MR_RUN;
                end
            end
            ST_MR_RUN: begin
                if (tmr_zero_i) begin
                    issue_o    = 1'b1;
                    cmd_o      = CMD_MRS_RUN;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CW'(T_MRD - 1);
                    step_d     = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (tmr_zero_i) begin
                    step_d = ST_DONE;
                end
            end
            ST_DONE: begin
                step_d = ST_DONE;
            end
            default: begin
                step_d = ST_PWAIT;
            end
        endcase
    end

    assign cke_en_o = (step_q != ST_PWAIT);
    assign done_o   = (step_q == ST_DONE);

    AST_ISSUE_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |-> tmr_zero_i); // R7
    AST_WAIT_WHILE_UNSTABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == ST_PWAIT && !pwr_stable_i) |=> (step_q == ST_PWAIT)); // R2
    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |=> (step_q != ST_PWAIT && step_q != $past(step_q))); // R4

endmodule

// File: rtl/ddr_init_pins.sv
// Module: ddr_init_pins
// Registered pin driver: turns the abstract command of the step machine
// into strobes, bank select and address. Idle cycles are Deselect while
// the clock enable is low and NOP once it is high.
// Assumes: DLL_RST_BIT < ADDR_W and ADDR_W > 10 (A10 is the all-bank flag).
module ddr_init_pins
    import ddr_init_pkg::*;
#(
    parameter int               ADDR_W      = 13,
    parameter int               BA_W        = 2,
    parameter logic [ADDR_W-1:0] MR_VALUE   = '0,
    parameter logic [ADDR_W-1:0] EMR_VALUE  = '0,
    parameter int               DLL_RST_BIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_en_i,
    input  logic              issue_i,
    input  init_cmd_e         cmd_i,
    output logic              cke_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RST_BIT;
    localparam logic [ADDR_W-1:0] ALL_BANK = ADDR_W'(1) << 10;

    logic [3:0] strb_d;
    logic [BA_W-1:0] ba_d;
    logic [ADDR_W-1:0] addr_d;

    // Form the next strobe pattern, bank select and address.
    always_comb begin
        strb_d = cke_en_i ? 4'b0111 : 4'b1111;
        ba_d   = '0;
        addr_d = '0;
        if (issue_i) begin
            case (cmd_i)
                CMD_PRE_ALL: begin
                    strb_d = 4'b0010;
                    addr_d = ALL_BANK;
                end
                CMD_REFRESH: strb_d = 4'b0001;
                CMD_MRS_EXT: begin
                    strb_d = 4'b0000;
                    ba_d   = BA_W'(1);
                    addr_d = EMR_VALUE;
                end
                CMD_MRS_DLLRST: begin
                    strb_d = 4'b0000;
                    addr_d = MR_VALUE | DLL_MASK;
                end
                CMD_MRS_RUN: begin
                    strb_d = 4'b0000;
                    addr_d = MR_VALUE & ~DLL_MASK;
                end
                default: strb_d = 4'b0111;
            endcase
        end
    end

    // Register every pin; reset parks the bus in Deselect with CKE low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_o                              <= 1'b0;
            {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= 4'b1111;
            ba_o                               <= '0;
            addr_o                             <= '0;
        end else begin
            cke_o                              <= cke_en_i;
            {cs_n_o, ras_n_o, cas_n_o, we_n_o} <= strb_d;
            ba_o                               <= ba_d;
            addr_o                             <= addr_d;
        end
    end

    AST_CKE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cke_o |=> cke_o); // R3

endmodule

// File: rtl/ddr_init_seq.sv
// Module: ddr_init_seq (top)
// Power-up initialization sequencer for a DDR SDRAM command bus. It
// derives the wall-clock wait and the timer width from its parameters
// and wires the step machine, the shared timer and the pin driver.
// Assumes: T_RP, T_MRD, T_RFC, DLL_LOCK_CYC >= 1; pwr_stable_i synchronous.
module ddr_init_seq #(
    parameter int               CLK_PERIOD_PS = 8000,
    parameter int               WAIT_US       = 200,
    parameter int               DLL_LOCK_CYC  = 200,
    parameter int               T_RP          = 3,
    parameter int               T_MRD         = 2,
    parameter int               T_RFC         = 9,
    parameter int               ADDR_W        = 13,
    parameter int               BA_W          = 2,
    parameter int               DLL_RST_BIT   = 8,
    parameter logic [ADDR_W-1:0] MR_VALUE     = 13'h0032,
    parameter logic [ADDR_W-1:0] EMR_VALUE    = 13'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_stable_i,
    output logic              cke_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              init_done_o
);
    import ddr_init_pkg::*;

    localparam int WAIT_CYC = (WAIT_US * 1000000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int LOCK_GAP = (DLL_LOCK_CYC > T_MRD) ? DLL_LOCK_CYC : T_MRD;
    localparam int MAX_A    = (WAIT_CYC > LOCK_GAP) ? WAIT_CYC : LOCK_GAP;
    localparam int MAX_B    = (T_RFC > T_RP) ? T_RFC : T_RP;
    localparam int MAX_CNT  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW       = $clog2(MAX_CNT + 1);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    logic          issue;
    init_cmd_e     cmd;
    logic          cke_en;

    ddr_init_timer #(
        .CW      (CW),
        .RST_VAL (CW'(WAIT_CYC - 1))
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    ddr_init_fsm #(
        .CW       (CW),
        .WAIT_CYC (WAIT_CYC),
        .T_RP     (T_RP),
        .T_MRD    (T_MRD),
        .T_RFC    (T_RFC),
        .LOCK_GAP (LOCK_GAP)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_stable_i (pwr_stable_i),
        .tmr_zero_i   (tmr_zero),
        .tmr_load_o   (tmr_load),
        .tmr_val_o    (tmr_val),
        .issue_o      (issue),
        .cmd_o        (cmd),
        .cke_en_o     (cke_en),
        .done_o       (init_done_o)
    );

    ddr_init_pins #(
        .ADDR_W      (ADDR_W),
        .BA_W        (BA_W),
        .MR_VALUE    (MR_VALUE),
        .EMR_VALUE   (EMR_VALUE),
        .DLL_RST_BIT (DLL_RST_BIT)
    ) pins_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke_en_i (cke_en),
        .issue_i  (issue),
        .cmd_i    (cmd),
        .cke_o    (cke_o),
        .cs_n_o   (cs_n_o),
        .ras_n_o  (ras_n_o),
        .cas_n_o  (cas_n_o),
        .we_n_o   (we_n_o),
        .ba_o     (ba_o),
        .addr_o   (addr_o)
    );

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |=> init_done_o); // R9
    AST_DONE_KEEPS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |-> cke_o); // R9
    AST_NOP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |-> ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111)); // R9
    AST_DESEL_BEFORE_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o |-> cs_n_o); // R2

endmodule

// File: tb/ddr_init_seq_tb.sv
// Bench for ddr_init_seq: a table of the seven expected commands (strobes,
// bank, address, minimum gap before each) is walked by one loop, then
// directed tests cover reset, the stability restart and a mid-run reset.
module ddr_init_seq_tb_top;

    localparam int CLK_PS   = 8000;
    localparam int W_US     = 2;
    localparam int LOCK     = 200;
    localparam int TRP      = 3;
    localparam int TMRD     = 2;
    localparam int TRFC     = 9;
    localparam logic [12:0] MRV  = 13'h0132;
    localparam logic [12:0] EMRV = 13'h0002;
    localparam int WAIT_CYC = (W_US * 1000000 + CLK_PS - 1) / CLK_PS;

    // {strobes[3:0], ba[1:0], addr[12:0], min gap before[15:0]}
    localparam logic [34:0] EXP_VEC [0:6] = '{
        {4'b0010, 2'b00, 13'h0400,            16'd1},
        {4'b0000, 2'b01, EMRV,                16'(TRP)},
        {4'b0000, 2'b00, MRV | 13'h0100,      16'(TMRD)},
        {4'b0010, 2'b00, 13'h0400,            16'(LOCK)},
        {4'b0001, 2'b00, 13'h0000,            16'(TRP)},
        {4'b0001, 2'b00, 13'h0000,            16'(TRFC)},
        {4'b0000, 2'b00, MRV & ~13'h0100,     16'(TRFC)}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stable = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, done;
    logic [1:0] ba;
    logic [12:0] addr;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ddr_init_seq #(
        .CLK_PERIOD_PS (CLK_PS),
        .WAIT_US       (W_US),
        .DLL_LOCK_CYC  (LOCK),
        .T_RP          (TRP),
        .T_MRD         (TMRD),
        .T_RFC         (TRFC),
        .MR_VALUE      (MRV),
        .EMR_VALUE     (EMRV)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_stable_i (stable),
        .cke_o        (cke),
        .cs_n_o       (cs_n),
        .ras_n_o      (ras_n),
        .cas_n_o      (cas_n),
        .we_n_o       (we_n),
        .ba_o         (ba),
        .addr_o       (addr),
        .init_done_o  (done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Waits out the power-up wait (counted from the call) and walks the table.
    task automatic run_seq();
        int n = 0;
        bit desel_ok = 1'b1;
        while (!cke && n < 20000) begin
            @(negedge clk);
            n++;
            if (!cke && !cs_n) desel_ok = 1'b0;
        end
        chk(desel_ok, "R2 deselect during wait", 0, 1);
        chk(n >= WAIT_CYC, "R2 wait length", n, WAIT_CYC);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R3 NOP with CKE rise",
            {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        for (int i = 0; i < 7; i++) begin
            int gap = 0;
            bit idle_ok = 1'b1;
            bit cke_ok = 1'b1;
            forever begin
                @(negedge clk);
                gap++;
                if (!cke) cke_ok = 1'b0;
                if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) begin
                    if (cs_n) idle_ok = 1'b0;
                    else break;
                end
                if (gap > 2000) break;
            end
            chk(cke_ok, "R3 CKE stays high", 0, 1);
            chk(idle_ok, "R5 idle cycles are NOP", 0, 1);
            chk({cs_n, ras_n, cas_n, we_n} == EXP_VEC[i][34:31], "R4 R5 command order",
                {cs_n, ras_n, cas_n, we_n}, EXP_VEC[i][34:31]);
            chk(ba == EXP_VEC[i][30:29], "R6 bank select", ba, EXP_VEC[i][30:29]);
            chk(addr == EXP_VEC[i][28:16], "R6 R5 address", addr, EXP_VEC[i][28:16]);
            if (i == 3) chk(gap >= int'(EXP_VEC[i][15:0]), "R8 DLL lock window", gap, EXP_VEC[i][15:0]);
            else        chk(gap >= int'(EXP_VEC[i][15:0]), "R7 command spacing", gap, EXP_VEC[i][15:0]);
            chk(!done, "R9 done early", done, 0);
        end
        begin
            int g = 0;
            bit quiet = 1'b1;
            while (!done && g < 2000) begin
                @(negedge clk);
                g++;
                if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) quiet = 1'b0;
            end
            chk(done == 1'b1, "R9 done rises", done, 1);
            chk(g >= TMRD, "R9 done spacing", g, TMRD);
            chk(quiet, "R4 no extra commands", 0, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!cke && cs_n && !done, "R1 reset state", {cke, cs_n, done}, 3'b010);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(!cke && cs_n, "R2 unstable hold", {cke, cs_n}, 2'b01);
        // Stability restart: 100 stable cycles, a dropout, then the full wait.
        stable = 1'b1;
        repeat (100) @(negedge clk);
        stable = 1'b0;
        repeat (5) @(negedge clk);
        chk(!cke, "R2 restart after dropout", cke, 0);
        stable = 1'b1;
        run_seq();
        begin
            bit idle_ok = 1'b1;
            for (int k = 0; k < 50; k++) begin
                @(negedge clk);
                if (!done || !cke || {cs_n, ras_n, cas_n, we_n} != 4'b0111) idle_ok = 1'b0;
            end
            chk(idle_ok, "R9 idle after done", 0, 1);
        end
        // Mid-sequence reset: let the run reach the DLL window, then reset.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (WAIT_CYC + 10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!cke && cs_n && !done, "R10 R1 mid-run reset", {cke, cs_n, done}, 3'b010);
        rst_n = 1'b1;
        run_seq();
        chk(done == 1'b1, "R10 full rerun", done, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule